// File: doc/BRIEF.md
# Addressed Two-Wire Bus Target

This block is the target (slave) side of a two-wire I2C bus. It samples the clock and data lines through a two-flop synchroniser, spots START and STOP conditions, and compares the first byte after each START with a programmable own address. Both 7-bit and 10-bit addressing are supported. It can optionally respond to the general-call address. When the address matches, it pulls the data line low in the acknowledge slot. Data then flows between the bus and two one-byte holding registers: a receive register, emptied by the host, and a transmit register, filled by the host.

The host side uses two valid/ready streams. The receive stream presents a byte with `rx_valid` and keeps `rx_data` stable until a cycle with `rx_valid` and `rx_ready` both high, which empties the register. The transmit stream takes a byte in a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is only raised while the block is waiting for a byte to send. When either stream is not ready, the block back-pressures the bus by holding the clock line low until the host catches up.

Protocol events are kept in four sticky flags. Each flag has its own enable bit, and the enabled flags together drive one interrupt line. The bus pins are modelled as open-drain: a high `*_oe` output means the line is pulled low.

Top module: `i2c_addr_slave`

## Requirements
- R1: After reset, neither bus line is pulled low, `rx_valid` and `tx_ready` are low, and all flags, `irq` and `gc_seen` are low.
- R2: With `addr10_en` low, a first byte whose upper seven bits equal `own_addr[6:0]` is acknowledged by pulling SDA low in the ninth clock. `own_addr[9:7]` has no effect. A byte that does not match is not acknowledged, and the block then ignores the bus until the next START.
- R3: With `addr10_en` high, a write is addressed by a header byte `11110` + `own_addr[9:8]` + `0`, followed by a byte equal to `own_addr[7:0]`. Both bytes are acknowledged, and a wrong low byte is not. A header with R/W = 1 is acknowledged only after a repeated START that follows a full 10-bit match. The match is forgotten at STOP.
- R4: The general-call byte `0x00` is acknowledged only when `gc_en` is high. It then raises `gc_seen`, which stays high until the next START, and it does not set the START flag.
- R5: While `force_nack` is high, the block acknowledges neither address nor data bytes and loads nothing into the receive register.
- R6: Received bytes are assembled MSB first and put on `rx_data` with `rx_valid` high. The value stays unchanged until it is taken.
- R7: If a data byte completes while the receive register is still full, SCL is held low and `scl_held` is high. The byte is loaded and acknowledged once the register has been emptied.
- R8: After a read-addressed match, SCL is held low (`scl_held` high) until a transmit byte is taken. Bits go out MSB first. A controller ACK leads to a request for the next byte. A controller NACK releases the bus and sets the NACK flag.
- R9: Flag bits are bit 3 NACK, bit 2 STOP, bit 1 START and bit 0 arbitration-lost. Bit 0 never sets in this slave-only block. START sets only on an own-address match. Flags stay set until a 1 is written to the same bit of `evt_clr`. `irq` is the OR of `evt_flags & evt_en`.
- R10: Every STOP condition on the bus sets the STOP flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | 10 | Own address, right-justified |
| addr10_en | input | 1 | 1 selects 10-bit own addressing |
| gc_en | input | 1 | 1 enables the general-call response |
| force_nack | input | 1 | 1 makes every acknowledge a NACK |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte is available |
| tx_ready | output | 1 | Block is waiting for a transmit byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Receive register holds a byte |
| rx_ready | input | 1 | Host takes the received byte |
| evt_en | input | 4 | Interrupt enable per flag |
| evt_clr | input | 4 | Write-one-to-clear per flag |
| evt_flags | output | 4 | Sticky event flags |
| irq | output | 1 | OR of the enabled flags |
| gc_seen | output | 1 | General call acknowledged in this transfer |
| scl_held | output | 1 | SCL is currently being held low |

## Verification
The bench goes after the address corners. It sets non-zero ignored bits in 7-bit mode, which a decoder comparing all ten bits would wrongly refuse. It sends a wrong 10-bit low byte and a read header with no prior full match. A decoder that trusts the header alone would acknowledge both. General call is tried with the enable off and on, and the bench confirms that it does not raise the START flag. Back-pressure is tested by leaving the receive register full and by withholding the transmit byte. A design that did not stretch would either overwrite the held byte or shift out stale data, and the bench would see a changed value or a released SCL.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W  = 8;
  localparam int OWN_W   = 10;
  localparam int FLG_N   = 4;
  localparam int CNT_W   = 4;
  localparam int FLG_AL    = 0;
  localparam int FLG_START = 1;
  localparam int FLG_STOP  = 2;
  localparam int FLG_NACK  = 3;
  localparam logic [4:0] HDR10 = 5'b11110;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR2, S_DECIDE, S_ACK_LO, S_ACK_HI,
    S_RX, S_RX_PUT, S_RX_HOLD, S_TX_GET, S_TX, S_TX_REL, S_TX_ACK
  } st_e;

  typedef enum logic [1:0] {NX_RX, NX_TX, NX_ADDR2} nxt_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= '1;
      else if (g == 0) chain[g] <= d;
      else chain[g] <= chain[(g == 0) ? 0 : g-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cs_busmon.sv
module i2cs_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  // data edges while the clock stays high mark bus conditions
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [OWN_W-1:0]  own_addr,
  input  logic              addr10_en,
  input  logic              gc_en,
  input  logic              force_nack,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic              gc_seen,
  output logic              ev_start,
  output logic              ev_nack
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  st_e               st;
  nxt_e              nxt;
  logic [BYTE_W-1:0] sh, rx_q;
  logic [CNT_W-1:0]  cnt;
  logic              ack_go, ten_ok, sda_oe_q, rx_full, gc_q;
  logic              ev_start_q, ev_nack_q;
  logic [BYTE_W-1:0] abyte;
  logic              dec_ack, dec_start, dec_gc, dec_ten;
  nxt_e              dec_nxt;

  assign abyte = {sh[BYTE_W-2:0], sda_s};

  // address decode on the byte completing at this rising edge
  always_comb begin
    dec_ack   = 1'b0;
    dec_start = 1'b0;
    dec_gc    = 1'b0;
    dec_ten   = 1'b0;
    dec_nxt   = NX_RX;
    if (st == S_ADDR2) begin
      if (abyte == own_addr[BYTE_W-1:0]) begin
        dec_ack   = 1'b1;
        dec_start = 1'b1;
        dec_ten   = 1'b1;
      end
    end else if (gc_en && abyte == '0) begin
      dec_ack = 1'b1;
      dec_gc  = 1'b1;
    end else if (!addr10_en && abyte[7:1] == own_addr[6:0]) begin
      dec_ack   = 1'b1;
      dec_start = 1'b1;
      dec_nxt   = abyte[0] ? NX_TX : NX_RX;
    end else if (addr10_en && abyte[7:3] == HDR10 &&
                 abyte[2:1] == own_addr[OWN_W-1:BYTE_W]) begin
      if (!abyte[0]) begin
        dec_ack = 1'b1;
        dec_nxt = NX_ADDR2;
      end else if (ten_ok) begin
        dec_ack   = 1'b1;
        dec_start = 1'b1;
        dec_nxt   = NX_TX;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  nxt <= NX_RX;  sh <= '0;  cnt <= '0;
      ack_go <= 1'b0;  ten_ok <= 1'b0;  sda_oe_q <= 1'b0;
      rx_full <= 1'b0;  rx_q <= '0;  gc_q <= 1'b0;
      ev_start_q <= 1'b0;  ev_nack_q <= 1'b0;
    end else begin
      ev_start_q <= 1'b0;
      ev_nack_q  <= 1'b0;
      if (rx_full && rx_ready) rx_full <= 1'b0;
      if (start_det) begin
        st <= S_ADDR;  cnt <= '0;  sda_oe_q <= 1'b0;  gc_q <= 1'b0;
      end else if (stop_det) begin
        st <= S_IDLE;  sda_oe_q <= 1'b0;  ten_ok <= 1'b0;
      end else begin
        unique case (st)
          S_IDLE: ;
          S_ADDR, S_ADDR2: if (scl_rise) begin
            sh  <= abyte;
            cnt <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              ack_go     <= dec_ack & ~force_nack;
              nxt        <= dec_nxt;
              ev_start_q <= dec_start & ~force_nack;
              gc_q       <= gc_q | (dec_gc & ~force_nack);
              if (dec_ten && !force_nack) ten_ok <= 1'b1;
              st <= S_DECIDE;
            end
          end
          S_DECIDE: if (scl_fall) begin
            if (ack_go) begin
              sda_oe_q <= 1'b1;
              st       <= S_ACK_LO;
            end else st <= S_IDLE;
          end
          S_ACK_LO: if (scl_rise) st <= S_ACK_HI;
          S_ACK_HI: if (scl_fall) begin
            sda_oe_q <= 1'b0;
            cnt      <= '0;
            unique case (nxt)
              NX_RX:    st <= S_RX;
              NX_ADDR2: st <= S_ADDR2;
              default:  st <= S_TX_GET;
            endcase
          end
          S_RX: if (scl_rise) begin
            sh  <= abyte;
            cnt <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              ack_go <= ~force_nack;
              st     <= S_RX_PUT;
            end
          end
          S_RX_PUT: if (scl_fall) st <= ack_go ? S_RX_HOLD : S_IDLE;
          S_RX_HOLD: if (!rx_full) begin
            rx_q     <= sh;
            rx_full  <= 1'b1;
            sda_oe_q <= 1'b1;
            nxt      <= NX_RX;
            st       <= S_ACK_LO;
          end
          S_TX_GET: if (tx_valid) begin
            sh       <= tx_data;
            sda_oe_q <= ~tx_data[BYTE_W-1];
            cnt      <= '0;
            st       <= S_TX;
          end
          S_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
              if (cnt == LAST_BIT) st <= S_TX_REL;
            end else if (scl_fall) begin
              sh       <= sh << 1;
              sda_oe_q <= ~sh[BYTE_W-2];
            end
          end
          S_TX_REL: if (scl_fall) begin
            sda_oe_q <= 1'b0;
            st       <= S_TX_ACK;
          end
          S_TX_ACK: if (scl_rise) begin
            if (!sda_s) begin
              nxt <= NX_TX;
              st  <= S_ACK_HI;
            end else begin
              ev_nack_q <= 1'b1;
              st        <= S_IDLE;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign sda_oe   = sda_oe_q;
  assign scl_oe   = (st == S_RX_HOLD) || (st == S_TX_GET);
  assign tx_ready = (st == S_TX_GET);
  assign rx_data  = rx_q;
  assign rx_valid = rx_full;
  assign gc_seen  = gc_q;
  assign ev_start = ev_start_q;
  assign ev_nack  = ev_nack_q;

  // R8
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe_q));

  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R7
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && !tx_valid && rx_valid && !rx_ready) |=> scl_oe);
endmodule

// File: rtl/i2cs_flags.sv
module i2cs_flags
  import i2cs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FLG_N-1:0] set_ev,
  input  logic [FLG_N-1:0] clr,
  input  logic [FLG_N-1:0] en,
  output logic [FLG_N-1:0] flags,
  output logic             irq
);
  for (genvar g = 0; g < FLG_N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[g] <= 1'b0;
      else if (set_ev[g]) flags[g] <= 1'b1;
      else if (clr[g]) flags[g] <= 1'b0;
    end

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[g] && !clr[g]) |=> flags[g]);
  end

  assign irq = |(flags & en);

  // R10
  stop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev[FLG_STOP] |=> flags[FLG_STOP]);
endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [OWN_W-1:0]  own_addr,
  input  logic              addr10_en,
  input  logic              gc_en,
  input  logic              force_nack,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic [FLG_N-1:0]  evt_en,
  input  logic [FLG_N-1:0]  evt_clr,
  output logic [FLG_N-1:0]  evt_flags,
  output logic              irq,
  output logic              gc_seen,
  output logic              scl_held
);
  logic [1:0] line_s;
  logic scl_rise, scl_fall, start_det, stop_det, ev_start, ev_nack;
  logic [FLG_N-1:0] set_ev;

  i2cs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(line_s)
  );

  i2cs_busmon u_mon (
    .clk(clk), .rst_n(rst_n), .scl_s(line_s[1]), .sda_s(line_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_engine u_eng (
    .clk(clk), .rst_n(rst_n), .scl_s(line_s[1]), .sda_s(line_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .own_addr(own_addr), .addr10_en(addr10_en), .gc_en(gc_en),
    .force_nack(force_nack), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .sda_oe(sda_oe), .scl_oe(scl_oe),
    .gc_seen(gc_seen), .ev_start(ev_start), .ev_nack(ev_nack)
  );

  always_comb begin
    set_ev            = '0;
    set_ev[FLG_NACK]  = ev_nack;
    set_ev[FLG_STOP]  = stop_det;
    set_ev[FLG_START] = ev_start;
    set_ev[FLG_AL]    = 1'b0;
  end

  i2cs_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr(evt_clr),
    .en(evt_en), .flags(evt_flags), .irq(irq)
  );

  assign scl_held = scl_oe;
endmodule

// File: tb/i2c_addr_slave_tb.sv
module i2c_addr_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_line, sda_line;
  logic scl_oe, sda_oe;
  logic [9:0] own_addr = 10'h35A;
  logic addr10_en = 1'b0, gc_en = 1'b0, force_nack = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_valid = 1'b0, tx_ready;
  logic [7:0] rx_data;
  logic rx_valid, rx_ready = 1'b0;
  logic [3:0] evt_en = 4'h0, evt_clr = 4'h0, evt_flags;
  logic irq, gc_seen, scl_held;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_line = !(m_scl_low || scl_oe);
  assign sda_line = !(m_sda_low || sda_oe);

  i2c_addr_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr),
    .addr10_en(addr10_en), .gc_en(gc_en), .force_nack(force_nack),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .evt_en(evt_en), .evt_clr(evt_clr), .evt_flags(evt_flags),
    .irq(irq), .gc_seen(gc_seen), .scl_held(scl_held)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic scl_up();
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; qwait(); scl_up(); qwait();
    m_sda_low = 1'b1; qwait(); m_scl_low = 1'b1; qwait();
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; qwait(); scl_up(); qwait();
    m_sda_low = 1'b0; qwait();
  endtask

  task automatic put_bit(input logic b);
    m_sda_low = !b; qwait(); scl_up(); qwait(); qwait();
    m_scl_low = 1'b1; qwait();
  endtask

  task automatic get_bit(output logic b);
    m_sda_low = 1'b0; qwait(); scl_up(); qwait();
    b = sda_line; qwait(); m_scl_low = 1'b1; qwait();
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    acked = !b;
  endtask

  task automatic rd_byte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(!ack);
  endtask

  task automatic rx_take(output logic [7:0] d);
    while (!rx_valid) @(negedge clk);
    d = rx_data;
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic tx_offer(input logic [7:0] d);
    tx_data = d;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic clr_flags();
    evt_clr = 4'hF; @(negedge clk); evt_clr = 4'h0;
  endtask

  task automatic t_reset();
    chk("R1", "scl_oe", scl_oe, 0);
    chk("R1", "sda_oe", sda_oe, 0);
    chk("R1", "rx_valid/tx_ready", {rx_valid, tx_ready}, 0);
    chk("R1", "flags/irq/gc", {evt_flags, irq, gc_seen}, 0);
  endtask

  task automatic t_write7();
    logic a; logic [7:0] d;
    bus_start();
    wr_byte({7'h5A, 1'b0}, a);
    chk("R2", "ack own 7-bit, upper bits ignored", a, 1);
    wr_byte(8'hC3, a);
    chk("R6", "data ack", a, 1);
    rx_take(d);
    chk("R6", "rx byte", d, 8'hC3);
    bus_stop(); qwait();
    chk("R10", "flags after write (stop+start)", evt_flags, 4'b0110);
    chk("R9", "irq masked", irq, 0);
    evt_en = 4'b0100; @(negedge clk);
    chk("R9", "irq via stop enable", irq, 1);
    evt_en = 4'h0; clr_flags();
    chk("R9", "flags cleared", evt_flags, 0);
  endtask

  task automatic t_mismatch();
    logic a;
    bus_start();
    wr_byte({7'h5B, 1'b0}, a);
    chk("R2", "no ack other address", a, 0);
    wr_byte(8'h00, a);
    chk("R2", "byte after mismatch ignored", a, 0);
    bus_stop(); qwait();
    chk("R2", "no rx after mismatch", rx_valid, 0);
    chk("R9", "start flag only on match", evt_flags, 4'b0100);
    clr_flags();
  endtask

  task automatic t_gcall();
    logic a; logic [7:0] d;
    gc_en = 1'b0;
    bus_start(); wr_byte(8'h00, a);
    chk("R4", "gc ignored when disabled", a, 0);
    bus_stop(); qwait();
    gc_en = 1'b1; clr_flags();
    bus_start(); wr_byte(8'h00, a);
    chk("R4", "gc acked when enabled", a, 1);
    chk("R4", "gc_seen", gc_seen, 1);
    wr_byte(8'h11, a); rx_take(d);
    chk("R4", "gc data", d, 8'h11);
    chk("R4", "gc no start flag", evt_flags[1], 0);
    bus_stop(); qwait();
    bus_start(); wr_byte({7'h11, 1'b0}, a);
    chk("R4", "gc_seen cleared by START", gc_seen, 0);
    bus_stop(); qwait();
    gc_en = 1'b0; clr_flags();
  endtask

  task automatic t_force_nack();
    logic a;
    force_nack = 1'b1;
    bus_start(); wr_byte({7'h5A, 1'b0}, a);
    chk("R5", "forced NACK on address", a, 0);
    bus_stop(); qwait();
    chk("R5", "nothing loaded", rx_valid, 0);
    force_nack = 1'b0; clr_flags();
  endtask

  task automatic t_rx_stretch();
    logic a, a2; logic [7:0] d, d2;
    bus_start(); wr_byte({7'h5A, 1'b0}, a);
    wr_byte(8'h01, a);
    fork
      wr_byte(8'h02, a2);
      begin
        repeat (500) @(negedge clk);
        chk("R7", "scl held while rx full", {scl_held, scl_line}, 2'b10);
        rx_take(d);
      end
    join
    chk("R7", "first byte kept", d, 8'h01);
    chk("R7", "second byte acked after drain", a2, 1);
    rx_take(d2);
    chk("R7", "second byte", d2, 8'h02);
    bus_stop(); qwait(); clr_flags();
  endtask

  task automatic t_read7();
    logic a; logic [7:0] d;
    bus_start(); wr_byte({7'h5A, 1'b1}, a);
    chk("R8", "read address acked", a, 1);
    fork
      rd_byte(d, 1'b1);
      begin
        repeat (100) @(negedge clk);
        chk("R8", "scl held until tx byte", {scl_held, scl_line}, 2'b10);
        tx_offer(8'hA5);
      end
    join
    chk("R8", "first tx byte", d, 8'hA5);
    fork
      rd_byte(d, 1'b0);
      tx_offer(8'h3C);
    join
    chk("R8", "second tx byte", d, 8'h3C);
    qwait();
    chk("R8", "nack flag and bus released", {evt_flags[3], sda_oe}, 2'b10);
    bus_stop(); qwait(); clr_flags();
  endtask

  task automatic t_ten_bit();
    logic a; logic [7:0] d;
    addr10_en = 1'b1; own_addr = 10'h2C7;
    bus_start(); wr_byte(8'hF4, a);
    chk("R3", "10-bit header acked", a, 1);
    wr_byte(8'hC7, a);
    chk("R3", "10-bit low byte acked", a, 1);
    chk("R9", "start flag on 10-bit match", evt_flags[1], 1);
    wr_byte(8'h5E, a); rx_take(d);
    chk("R3", "10-bit data", d, 8'h5E);
    bus_start(); wr_byte(8'hF5, a);
    chk("R3", "10-bit read header after match", a, 1);
    fork
      rd_byte(d, 1'b0);
      tx_offer(8'h96);
    join
    chk("R3", "10-bit read data", d, 8'h96);
    bus_stop(); qwait(); clr_flags();
    bus_start(); wr_byte(8'hF4, a); wr_byte(8'hC6, a);
    chk("R3", "wrong 10-bit low byte", a, 0);
    bus_stop(); qwait();
    bus_start(); wr_byte(8'hF5, a);
    chk("R3", "read header without prior match", a, 0);
    bus_stop(); qwait(); clr_flags();
    addr10_en = 1'b0; own_addr = 10'h35A;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write7();
    t_mismatch();
    t_gcall();
    t_force_nack();
    t_rx_stretch();
    t_read7();
    t_ten_bit();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule